// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the instruction address register of a small 16-bit processor and works out, once per clock, where execution goes next. The decoder gives it a source select, a branch enable with a 3-bit condition code, and the operands and targets the current instruction may need. The unit then loads one of five values: the following instruction, a PC-relative branch target, a register value, an absolute address or the address popped from the return stack.

The signed comparison for conditional branches is done inside the unit, so the decoder only passes the two register operands and a condition code. A halt input freezes the counter. A synchronous reset returns it to address zero and takes precedence over halt. Along with the current PC, the unit gives the return stack PC+1 from a second register, so both outputs come straight from flops.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `pc` becomes 0 and `pc_inc` becomes 1, whatever `halt` is.
- R2: With `rst` 0 and `halt` 1, `pc` keeps its value at every clock edge, including when a branch or jump is requested.
- R3: With `halt` 0, `br_en` 0 and `src` = 0 (sequential), `pc` becomes `pc + 1`, wrapping from 0xFFFF to 0x0000.
- R4: `pc_inc` always equals `pc + 1` modulo 2^16.
- R5: With `br_en` 1 and the condition true, `pc` becomes `pc` plus `br_off` sign-extended from 8 bits, modulo 2^16.
- R6: With `br_en` 1 and the condition false, `pc` becomes `pc + 1`.
- R7: Condition codes on `br_cc` compare `op_a` against `op_b` as two's-complement values: 0 equal, 1 not equal, 2 less than, 3 greater or equal, 4 less or equal, 5 greater than.
- R8: Condition codes 6 and 7 are never taken.
- R9: With `br_en` 0 and `src` = 1, `pc` becomes `reg_tgt`.
- R10: With `br_en` 0 and `src` = 2, `pc` becomes `abs_tgt`.
- R11: With `br_en` 0 and `src` = 3, `pc` becomes `ret_addr`.
- R12: When `br_en` is 1, `src` is ignored and only the branch outcome decides the next `pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Freeze the counter |
| src | input | 2 | Next-address source when not branching |
| br_en | input | 1 | Current instruction is a conditional branch |
| br_cc | input | 3 | Branch condition code |
| op_a | input | 16 | First comparison operand |
| op_b | input | 16 | Second comparison operand |
| br_off | input | 8 | Signed branch displacement |
| abs_tgt | input | 16 | Absolute jump or call target |
| reg_tgt | input | 16 | Register-indirect target |
| ret_addr | input | 16 | Return address from the return stack |
| pc | output | 16 | Current program counter |
| pc_inc | output | 16 | Current program counter plus one |

## Verification
The bench uses the default widths: a 16-bit counter and an 8-bit displacement. At that size all 256 displacements can be swept from a base address near zero, so each backward branch that wraps below 0x0000 is covered. All eight condition codes are crossed with a grid of operands that includes zero, ±1, both signed extremes and their neighbours, which exercises the sign-boundary cases of the comparator. Directed steps cover the wrap from 0xFFFF, halting with a request pending, reset during halt, and a branch asserted alongside a jump source.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_REG = 2'd1,
    SRC_ABS = 2'd2,
    SRC_RET = 2'd3
  } pc_src_e;

  typedef enum logic [2:0] {
    CC_EQ   = 3'd0,
    CC_NE   = 3'd1,
    CC_LT   = 3'd2,
    CC_GE   = 3'd3,
    CC_LE   = 3'd4,
    CC_GT   = 3'd5,
    CC_RSV6 = 3'd6,
    CC_RSV7 = 3'd7
  } br_cond_e;

endpackage

// File: rtl/pcu_branch_cmp.sv
module pcu_branch_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   br_cc,
  output logic         taken
);
  import pcu_pkg::*;

  localparam int MSB = W - 1;

  logic eq, lt_u, lt_s;

  always_comb begin
    eq   = (op_a == op_b);
    lt_u = (op_a < op_b);
    // differing signs: the negative one is smaller
    lt_s = (op_a[MSB] ^ op_b[MSB]) ? op_a[MSB] : lt_u;
  end

  always_comb begin
    unique case (br_cc)
      CC_EQ:   taken = eq;
      CC_NE:   taken = !eq;
      CC_LT:   taken = lt_s;
      CC_GE:   taken = !lt_s;
      CC_LE:   taken = lt_s | eq;
      CC_GT:   taken = !(lt_s | eq);
      default: taken = 1'b0;
    endcase
  end

  // R8: reserved codes never produce a taken branch
  always_comb begin
    if (br_cc == CC_RSV6 || br_cc == CC_RSV7)
      a_r8_reserved_not_taken: assert (!taken);
  end

endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel #(
  parameter int W    = 16,
  parameter int OFFW = 8
) (
  input  logic [W-1:0]    pc,
  input  logic            halt,
  input  logic            br_en,
  input  logic            taken,
  input  logic [1:0]      src,
  input  logic [OFFW-1:0] br_off,
  input  logic [W-1:0]    reg_tgt,
  input  logic [W-1:0]    abs_tgt,
  input  logic [W-1:0]    ret_addr,
  output logic [W-1:0]    nxt
);
  import pcu_pkg::*;

  localparam logic [W-1:0] INC = W'(1);

  logic [W-1:0] off_ext;
  logic [W-1:0] seq_pc;

  generate
    if (OFFW < W) begin : g_sext
      assign off_ext = {{(W-OFFW){br_off[OFFW-1]}}, br_off};
    end else begin : g_trunc
      assign off_ext = br_off[W-1:0];
    end
  endgenerate

  assign seq_pc = pc + INC;

  always_comb begin
    if (halt) begin
      nxt = pc;
    end else if (br_en) begin
      nxt = taken ? (pc + off_ext) : seq_pc;
    end else begin
      unique case (src)
        SRC_REG: nxt = reg_tgt;
        SRC_ABS: nxt = abs_tgt;
        SRC_RET: nxt = ret_addr;
        default: nxt = seq_pc;
      endcase
    end
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int W    = 16,
  parameter int OFFW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            halt,
  input  logic [1:0]      src,
  input  logic            br_en,
  input  logic [2:0]      br_cc,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic [OFFW-1:0] br_off,
  input  logic [W-1:0]    abs_tgt,
  input  logic [W-1:0]    reg_tgt,
  input  logic [W-1:0]    ret_addr,
  output logic [W-1:0]    pc,
  output logic [W-1:0]    pc_inc
);
  import pcu_pkg::*;

  localparam logic [W-1:0] INC = W'(1);

  logic         taken;
  logic [W-1:0] nxt;

  pcu_branch_cmp #(.W(W)) u_cmp (
    .op_a  (op_a),
    .op_b  (op_b),
    .br_cc (br_cc),
    .taken (taken)
  );

  pcu_next_sel #(.W(W), .OFFW(OFFW)) u_sel (
    .pc       (pc),
    .halt     (halt),
    .br_en    (br_en),
    .taken    (taken),
    .src      (src),
    .br_off   (br_off),
    .reg_tgt  (reg_tgt),
    .abs_tgt  (abs_tgt),
    .ret_addr (ret_addr),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      pc_inc <= INC;
    end else begin
      pc     <= nxt;
      pc_inc <= nxt + INC;
    end
  end

  // R1
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (pc == '0 && pc_inc == INC));

  // R2
  a_r2_halt_holds: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc));

  // R4
  a_r4_inc_tracks: assert property (@(posedge clk) disable iff (rst)
    pc_inc == W'(pc + INC));

  // R3
  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (!halt && !br_en && src == SRC_SEQ) |=> pc == W'($past(pc) + INC));

  // R10
  a_r10_absolute: assert property (@(posedge clk) disable iff (rst)
    (!halt && !br_en && src == SRC_ABS) |=> pc == $past(abs_tgt));

  // R11
  a_r11_return: assert property (@(posedge clk) disable iff (rst)
    (!halt && !br_en && src == SRC_RET) |=> pc == $past(ret_addr));

  // R9
  a_r9_register: assert property (@(posedge clk) disable iff (rst)
    (!halt && !br_en && src == SRC_REG) |=> pc == $past(reg_tgt));

endmodule

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
  localparam int W  = 16;
  localparam int OW = 8;

  logic          clk = 1'b0;
  logic          rst, halt, br_en;
  logic [1:0]    src;
  logic [2:0]    br_cc;
  logic [W-1:0]  op_a, op_b, abs_tgt, reg_tgt, ret_addr;
  logic [OW-1:0] br_off;
  logic [W-1:0]  pc, pc_inc;

  int nrun  = 0;
  int nfail = 0;
  logic [W-1:0] m_pc = '0;

  always #5 clk = ~clk;

  pc_next_unit #(.W(W), .OFFW(OW)) i_pc_next_unit (
    .clk(clk), .rst(rst), .halt(halt), .src(src), .br_en(br_en),
    .br_cc(br_cc), .op_a(op_a), .op_b(op_b), .br_off(br_off),
    .abs_tgt(abs_tgt), .reg_tgt(reg_tgt), .ret_addr(ret_addr),
    .pc(pc), .pc_inc(pc_inc)
  );

  function automatic bit cond_true(logic [2:0] c, logic [W-1:0] a, logic [W-1:0] b);
    int sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    case (c)
      3'd0: return sa == sb;
      3'd1: return sa != sb;
      3'd2: return sa <  sb;
      3'd3: return sa >= sb;
      3'd4: return sa <= sb;
      3'd5: return sa >  sb;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [W-1:0] model_next();
    int d;
    if (rst)  return '0;
    if (halt) return m_pc;
    if (br_en) begin
      d = $signed(br_off);
      if (cond_true(br_cc, op_a, op_b)) return W'((int'(m_pc) + d) & 32'hFFFF);
      return W'((int'(m_pc) + 1) & 32'hFFFF);
    end
    case (src)
      2'd1: return reg_tgt;
      2'd2: return abs_tgt;
      2'd3: return ret_addr;
      default: return W'((int'(m_pc) + 1) & 32'hFFFF);
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    logic [W-1:0] e;
    e = model_next();
    @(posedge clk);
    #1;
    check(tag, pc, e);
    check("R4", pc_inc, W'((int'(e) + 1) & 32'hFFFF));
    m_pc = e;
  endtask

  task automatic idle();
    rst = 0; halt = 0; br_en = 0; src = 2'd0; br_cc = 3'd0;
    op_a = '0; op_b = '0; br_off = '0;
  endtask

  task automatic jump_to(logic [W-1:0] v);
    idle();
    src = 2'd2;
    abs_tgt = v;
    tick("R10");
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    logic [W-1:0] vals [10];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000,
             16'hFFFF, 16'hFFFE, 16'h1234, 16'h8001, 16'h7FFE};
    idle();
    abs_tgt = 16'h0BAD; reg_tgt = 16'h0C0C; ret_addr = 16'h0D0D;
    rst = 1; halt = 1;
    tick("R1");
    tick("R1");

    idle();
    for (int i = 0; i < 5; i++) tick("R3");

    // halt with pending requests
    halt = 1; src = 2'd2; abs_tgt = 16'h5555;
    tick("R2");
    br_en = 1; br_cc = 3'd0; br_off = 8'h40;
    tick("R2");
    tick("R2");

    // wrap of sequential increment
    jump_to(16'hFFFE);
    idle();
    tick("R3");
    tick("R3");
    tick("R3");

    idle(); src = 2'd1; reg_tgt = 16'hA5A5; tick("R9");
    idle(); src = 2'd3; ret_addr = 16'h3C3C; tick("R11");
    jump_to(16'h0777);

    // branch overrides jump sources
    idle(); br_en = 1; br_cc = 3'd0; op_a = 16'h9; op_b = 16'h9;
    br_off = 8'h05; src = 2'd2; abs_tgt = 16'h1111;
    tick("R12");
    br_cc = 3'd1; src = 2'd3; ret_addr = 16'h2222;
    tick("R12");
    br_cc = 3'd6; src = 2'd1; reg_tgt = 16'h3333;
    tick("R12");

    // all displacements from near zero
    for (int o = 0; o < 256; o++) begin
      jump_to(16'h0004);
      idle(); br_en = 1; br_cc = 3'd0; br_off = OW'(o);
      tick("R5");
    end

    // all condition codes over an operand grid
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          jump_to(16'h4000);
          idle(); br_en = 1; br_cc = 3'(c);
          op_a = vals[i]; op_b = vals[j]; br_off = 8'hF0;
          if (c >= 6) tick("R8");
          else if (cond_true(br_cc, op_a, op_b)) tick("R7");
          else tick("R6");
        end
      end
    end

    // reset overrides halt mid-run
    jump_to(16'h6000);
    idle(); rst = 1; halt = 1;
    tick("R1");
    idle();
    tick("R3");

    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule